// File: doc/BRIEF.md
# Startup-Latched Frequency Profile Selector

This block holds an eight-row table of PLL frequency profiles and presents one row at a time to downstream clock-generation logic. Each row carries a PLL feedback multiplier (P, 11 bits), a PLL reference divider (Q, 8 bits) and a one-bit flag that picks which of two output-divider register banks the two divided clock outputs use. Both of those outputs always use the same bank.

The 3-bit row index is built from two sources. The two low bits are strap pins that are shared with the serial port and sampled once, on the first clock edge after reset is released. After that sample they are frozen. The high bit is a live general-purpose select input. It passes through a two-flop synchronizer, and a configuration input can force it to zero.

A simple register write port models serial reprogramming of the table. A one-cycle strobe tells consumers that the presented settings have changed. This happens either because the index moved or because the row in use was rewritten.

Top module: `fps_profile_select`

## Requirements
- R1: During reset, and on the first clock edge after reset is released, the outputs show row 0 and `prof_chg` is 0. Reset loads row r (0..7) with Q = r + 1, P = 64 + 16·r and bank flag = bit 0 of r.
- R2: On the first rising edge with `rst_n` high, `strap_pins[1:0]` is captured. From the second edge on, the active index is {hi, strap_pins[1], strap_pins[0]}, where hi is the high index bit.
- R3: Changes on `strap_pins` after the capture edge have no effect on the outputs or on `prof_chg`.
- R4: With `hi_sel_en` = 1, hi follows `hi_sel_pin` through two synchronizing flops. The outputs reflect a new pin value on the third rising edge after the pin changes.
- R5: With `hi_sel_en` = 0, hi is 0 whatever `hi_sel_pin` does. A change of `hi_sel_en` takes effect on the next edge.
- R6: `pll_p`, `pll_q` and `div_bank` always show the P, Q and bank flag stored in the active row.
- R7: A write (`wr_en` = 1) stores `wr_p`, `wr_q` and `wr_bank` into row `wr_addr` at the rising edge. The stored values are visible in the cycle that follows that edge.
- R8: `prof_chg` is 1 for exactly the cycle after each edge at which the active index changes.
- R9: A write to the row that is active after the edge raises `prof_chg` for one cycle, even when the data are unchanged. A write to any other row leaves `prof_chg` at 0 and leaves the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_pins | input | 2 | Shared strap/serial pins; provide the low index bits at startup |
| hi_sel_pin | input | 1 | Asynchronous live select input for the high index bit |
| hi_sel_en | input | 1 | Configuration bit; 1 lets `hi_sel_pin` drive the high index bit |
| wr_en | input | 1 | Table write enable |
| wr_addr | input | 3 | Row to write |
| wr_p | input | 11 | Feedback multiplier value to write |
| wr_q | input | 8 | Reference divider value to write |
| wr_bank | input | 1 | Divider-bank flag to write |
| pll_p | output | 11 | Active row feedback multiplier |
| pll_q | output | 8 | Active row reference divider |
| div_bank | output | 1 | Active row divider-bank flag |
| prof_chg | output | 1 | One-cycle pulse on a change of the presented profile |

## Verification
The assertions take for granted that reset is held low for at least two clock edges, so that every register, including both synchronizer flops, starts from a known value. They also assume that `strap_pins` and `wr_en` are defined at the capture edge. The bench holds reset for three edges and drives `wr_en` low during reset. It changes inputs only just after falling edges, so the strap sample and every write see settled values.

Each sweep covers one of the four strap codes, both values of the live select bit, both values of the enable bit, and writes to every row. Expected rows come from the reset formula and the written patterns, computed in the bench.

// File: rtl/fps_pkg.sv
// Package: shared widths and the row type of the frequency profile selector.
// Assumes an index of IDX_W bits, where all but the top bit come from straps.
package fps_pkg;
    localparam int P_W     = 11;
    localparam int Q_W     = 8;
    localparam int IDX_W   = 3;
    localparam int ROWS    = 1 << IDX_W;
    localparam int STRAP_W = IDX_W - 1;
    localparam int DEF_P_BASE = 64;
    localparam int DEF_P_STEP = 16;

    typedef struct packed {
        logic           bank;
        logic [P_W-1:0] p;
        logic [Q_W-1:0] q;
    } prof_row_t;

    // Reset contents of row r: Q = r+1, P = base + step*r, bank = r[0]
    function automatic prof_row_t default_row(input int unsigned r);
        prof_row_t row;
        row.q    = Q_W'(r + 1);
        row.p    = P_W'(DEF_P_BASE + DEF_P_STEP * r);
        row.bank = r[0];
        return row;
    endfunction
endpackage

// File: rtl/fps_strap_latch.sv
// Module: samples the strap pins once, on the first edge after reset release,
// and holds them until the next reset. Assumes pins settle before that edge.
module fps_strap_latch #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins,
    output logic [W-1:0] strap,
    output logic         captured
);

    // One-shot capture of the strap pins after reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strap    <= '0;
            captured <= 1'b0;
        end else if (!captured) begin
            strap    <= pins;
            captured <= 1'b1;
        end
    end

    AST_CAPTURE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> captured); // R2

endmodule

// File: rtl/fps_sync2.sv
// Module: two-flop synchronizer for an asynchronous level input.
// Assumes the input is a slow level; no pulse capture is attempted.
module fps_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);

    logic [W-1:0] meta;

    // Two-stage resynchronization into the clk domain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta   <= '0;
            q_sync <= '0;
        end else begin
            meta   <= d_async;
            q_sync <= meta;
        end
    end

    AST_SYNC_TWO_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n, 2) |-> q_sync == $past(d_async, 2)); // R4

endmodule

// File: rtl/fps_profile_table.sv
// Module: ROWS-entry profile register table with reset defaults, one write
// port and one asynchronous read port. Assumes writes are single-row per edge.
module fps_profile_table
    import fps_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_addr,
    input  prof_row_t        wr_row,
    input  logic [IDX_W-1:0] rd_addr,
    output prof_row_t        rd_row
);

    prof_row_t rows [ROWS];

    for (genvar g = 0; g < ROWS; g++) begin : g_row
        // Row register: reset to its default, load on an addressed write
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rows[g] <= default_row(g);
            end else if (wr_en && (wr_addr == IDX_W'(g))) begin
                rows[g] <= wr_row;
            end
        end
    end

    // Read mux for the active row
    always_comb begin
        rd_row = rows[rd_addr];
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_en) && $past(rst_n)) |-> rows[$past(wr_addr)] == $past(wr_row)); // R7

endmodule

// File: rtl/fps_profile_select.sv
// Module: top of the startup-latched frequency profile selector. Builds the
// row index from latched straps and a synchronized live select bit, presents
// the active row, and pulses prof_chg when the presented profile changes.
// Assumes rst_n is held low for at least two clock edges.
module fps_profile_select
    import fps_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STRAP_W-1:0] strap_pins,
    input  logic               hi_sel_pin,
    input  logic               hi_sel_en,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_addr,
    input  logic [P_W-1:0]     wr_p,
    input  logic [Q_W-1:0]     wr_q,
    input  logic               wr_bank,
    output logic [P_W-1:0]     pll_p,
    output logic [Q_W-1:0]     pll_q,
    output logic               div_bank,
    output logic               prof_chg
);

    logic [STRAP_W-1:0] strap;
    logic               cap_done;
    logic               hi_sync;
    logic [IDX_W-1:0]   idx_next;
    logic [IDX_W-1:0]   cur_idx;
    prof_row_t          wr_row;
    prof_row_t          act_row;

    fps_strap_latch #(.W(STRAP_W)) u_strap (
        .clk      (clk),
        .rst_n    (rst_n),
        .pins     (strap_pins),
        .strap    (strap),
        .captured (cap_done)
    );

    fps_sync2 #(.W(1)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (hi_sel_pin),
        .q_sync  (hi_sync)
    );

    // Pack the write port fields into a row
    always_comb begin
        wr_row.bank = wr_bank;
        wr_row.p    = wr_p;
        wr_row.q    = wr_q;
    end

    fps_profile_table u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_row  (wr_row),
        .rd_addr (cur_idx),
        .rd_row  (act_row)
    );

    // Next index: row 0 until straps are captured, then {hi, straps}
    always_comb begin
        if (cap_done) begin
            idx_next = {hi_sync & hi_sel_en, strap};
        end else begin
            idx_next = '0;
        end
    end

    // Active index register and change strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_idx  <= '0;
            prof_chg <= 1'b0;
        end else begin
            cur_idx  <= idx_next;
            prof_chg <= (idx_next != cur_idx) || (wr_en && (wr_addr == idx_next));
        end
    end

    // Drive the presented profile from the active row
    always_comb begin
        pll_p    = act_row.p;
        pll_q    = act_row.q;
        div_bank = act_row.bank;
    end

    AST_ROW0_BEFORE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_done |-> cur_idx == '0); // R1

    AST_STRAP_BITS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cap_done, 2) |-> cur_idx[STRAP_W-1:0] == $past(cur_idx[STRAP_W-1:0])); // R3

    AST_HI_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(hi_sel_en) |-> !cur_idx[IDX_W-1]); // R5

    AST_IDX_CHANGE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_idx != $past(cur_idx)) |-> prof_chg); // R8

    AST_ACTIVE_WRITE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en) && ($past(wr_addr) == cur_idx)) |-> prof_chg); // R9

    AST_QUIET_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_en) && (cur_idx == $past(cur_idx))) |-> !prof_chg); // R8

endmodule

// File: tb/fps_profile_select_tb.sv
module fps_profile_select_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  strap_pins = 2'b00;
    logic        hi_sel_pin = 1'b0;
    logic        hi_sel_en = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = 3'd0;
    logic [10:0] wr_p = '0;
    logic [7:0]  wr_q = '0;
    logic        wr_bank = 1'b0;
    logic [10:0] pll_p;
    logic [7:0]  pll_q;
    logic        div_bank;
    logic        prof_chg;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    int mp_p [8];
    int mp_q [8];
    int mp_b [8];

    always #2.5 clk = ~clk;

    fps_profile_select u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .strap_pins (strap_pins),
        .hi_sel_pin (hi_sel_pin),
        .hi_sel_en  (hi_sel_en),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_p       (wr_p),
        .wr_q       (wr_q),
        .wr_bank    (wr_bank),
        .pll_p      (pll_p),
        .pll_q      (pll_q),
        .div_bank   (div_bank),
        .prof_chg   (prof_chg)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_row(input string req, input int r);
        chk({req, " P"}, int'(pll_p), mp_p[r]);
        chk({req, " Q"}, int'(pll_q), mp_q[r]);
        chk({req, " bank"}, int'(div_bank), mp_b[r]);
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_reset(input int s);
        rst_n = 1'b0;
        strap_pins = 2'(s);
        hi_sel_pin = 1'b0;
        hi_sel_en = 1'b1;
        wr_en = 1'b0;
        for (int r = 0; r < 8; r++) begin
            mp_p[r] = 64 + 16 * r;
            mp_q[r] = r + 1;
            mp_b[r] = r & 1;
        end
        repeat (3) step();
        chk_row("R1 reset row0", 0);
        chk("R1 reset strobe", int'(prof_chg), 0);
        rst_n = 1'b1;
    endtask

    task automatic write_row(input int r, input int p, input int q, input int b);
        wr_en = 1'b1;
        wr_addr = 3'(r);
        wr_p = 11'(p);
        wr_q = 8'(q);
        wr_bank = b[0];
        step();
        wr_en = 1'b0;
        mp_p[r] = p & 11'h7ff;
        mp_q[r] = q & 8'hff;
        mp_b[r] = b & 1;
    endtask

    initial begin
        for (int s = 0; s < 4; s++) begin
            int hi_row;
            hi_row = 4 + s;
            do_reset(s);
            // first edge after release: still row 0
            step();
            chk_row("R1 row0 at capture edge", 0);
            chk("R1 no strobe at capture edge", int'(prof_chg), 0);
            // second edge: strap index active
            step();
            chk_row("R2 strap row", s);
            chk("R8 strobe on strap index", int'(prof_chg), (s != 0) ? 1 : 0);
            step();
            chk("R8 strobe single cycle", int'(prof_chg), 0);
            // strap pins move after capture
            strap_pins = 2'(~s);
            for (int k = 0; k < 3; k++) begin
                step();
                chk_row("R3 strap ignored", s);
                chk("R3 no strobe", int'(prof_chg), 0);
            end
            // live select rises: visible on third edge
            hi_sel_pin = 1'b1;
            step();
            chk_row("R4 sync stage 1", s);
            chk("R4 no early strobe", int'(prof_chg), 0);
            step();
            chk_row("R4 sync stage 2", s);
            step();
            chk_row("R4 high row", hi_row);
            chk("R8 strobe on hi change", int'(prof_chg), 1);
            step();
            chk("R8 strobe drops", int'(prof_chg), 0);
            // mask the high bit
            hi_sel_en = 1'b0;
            step();
            chk_row("R5 masked row", s);
            chk("R5 strobe on mask", int'(prof_chg), 1);
            hi_sel_pin = 1'b0;
            repeat (3) step();
            hi_sel_pin = 1'b1;
            for (int k = 0; k < 3; k++) begin
                step();
                chk_row("R5 pin ignored", s);
                chk("R5 no strobe", int'(prof_chg), 0);
            end
            hi_sel_en = 1'b1;
            step();
            chk_row("R5 unmask row", hi_row);
            chk("R8 strobe on unmask", int'(prof_chg), 1);
            step();
            // write the active row
            write_row(hi_row, hi_row * 97 + s * 31 + 5, hi_row * 13 + s * 7 + 3, ~hi_row & 1);
            chk_row("R7 active row written", hi_row);
            chk("R9 strobe on active write", int'(prof_chg), 1);
            step();
            chk("R9 strobe single cycle", int'(prof_chg), 0);
            // same data again still strobes
            write_row(hi_row, mp_p[hi_row], mp_q[hi_row], mp_b[hi_row]);
            chk("R9 strobe on same-data write", int'(prof_chg), 1);
            chk_row("R6 active row shown", hi_row);
            // write every other row: no strobe, no output change
            for (int r = 0; r < 8; r++) begin
                if (r != hi_row) begin
                    write_row(r, r * 97 + s * 31 + 5, r * 13 + s * 7 + 3, ~r & 1);
                    chk("R9 no strobe on inactive write", int'(prof_chg), 0);
                    chk_row("R9 outputs unchanged", hi_row);
                end
            end
            // return to the low row and read its written contents
            hi_sel_pin = 1'b0;
            step();
            step();
            step();
            chk_row("R7 written low row", s);
            chk("R8 strobe on return", int'(prof_chg), 1);
            step();
            chk("R8 strobe drops", int'(prof_chg), 0);
        end
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule